// File: doc/BRIEF.md
# Conditional Branch and Loop Unit

This unit resolves the control-transfer decision for the conditional branches and the count-down loop instruction of a 16-bit minicomputer. Each time `issue` is high at a rising clock edge it takes the instruction word, the program counter (already advanced past the instruction), the four condition flags N, Z, V, C and the current value of the register named by a loop instruction. One cycle later it reports whether control moves and to which address. The flags are only read; the unit has no path that could alter them.

Branches fall into two groups, chosen by bit 15 of the instruction. One group tests the signed relations, equality and the unconditional case. The other tests single flags and the unsigned relations. Both groups add twice a sign-extended 8-bit word offset. The loop instruction decrements its register, and the unit returns the new value with a write strobe so that the surrounding datapath can store it. It branches backward by twice an unsigned 6-bit offset while the decremented count is nonzero.

A small state machine carries the result of each issue into the output cycle. Its states are `ST_IDLE` (nothing issued last cycle), `ST_BRANCH` (a branch was issued), `ST_LOOP` (a loop instruction was issued) and `ST_PASS` (an instruction that is not a control transfer was issued). On every edge the next state follows `issue` and the decoded class of the instruction: IDLE/any -> BRANCH on a branch issue, any -> LOOP on a loop issue, any -> PASS on any other issue, and any -> IDLE when `issue` is low. The captured results are cleared in reset.

Top module: `bl_unit`

## Requirements
- R1: While reset is applied and after it is released with no issue, `done`, `ctl_hit`, `taken` and `loop_wr` are low, and `pc_out`, `loop_idx` and `loop_data` are zero.
- R2: An issue sampled at a rising edge produces its results in the following cycle with `done` high for that one cycle; a cycle with no issue before it shows `done`, `ctl_hit`, `taken` and `loop_wr` low and `pc_out` zero.
- R3: A high byte of 0x01 to 0x07 is a branch (`ctl_hit` high) taken when: 0x01 always; 0x02 Z=0; 0x03 Z=1; 0x04 N xor V = 0; 0x05 N xor V = 1; 0x06 Z or (N xor V) = 0; 0x07 Z or (N xor V) = 1.
- R4: A high byte of 0x80 to 0x87 is a branch taken when: 0x80 N=0; 0x81 N=1; 0x82 C or Z = 0; 0x83 C or Z = 1; 0x84 V=0; 0x85 V=1; 0x86 C=0; 0x87 C=1.
- R5: A taken branch gives `pc_out` = `pc_in` + 2 x (low byte read as a signed 8-bit number), modulo 2^16, so the reach is -256 to +254 bytes.
- R6: An untaken branch, and any instruction outside R3, R4 and R7 (for example high byte 0x00 or 0x88, or bits 15..9 other than 0111111), gives `taken` low and `pc_out` = `pc_in`; such non-control instructions also give `ctl_hit` and `loop_wr` low.
- R7: An instruction with bits 15..9 equal to 0111111 is the loop instruction: `ctl_hit` and `loop_wr` are high, `loop_idx` equals bits 8..6 and `loop_data` equals `loop_val` - 1 modulo 2^16, whether or not it branches.
- R8: The loop instruction is taken exactly when `loop_data` is nonzero, and then `pc_out` = `pc_in` - 2 x (bits 5..0 read unsigned), modulo 2^16.
- R9: Issues on consecutive edges each produce their own results in consecutive cycles, with `done` staying high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| issue | input | 1 | Instruction presented for evaluation this edge |
| instr | input | 16 | Instruction word |
| pc_in | input | 16 | Program counter past the instruction |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| loop_val | input | 16 | Value of the register selected by a loop instruction |
| done | output | 1 | Result cycle for the previous issue |
| ctl_hit | output | 1 | Previous issue was a branch or loop instruction |
| taken | output | 1 | Control transfers to `pc_out` |
| pc_out | output | 16 | Next program counter |
| loop_wr | output | 1 | Write strobe for the decremented loop register |
| loop_idx | output | 3 | Index of the loop register |
| loop_data | output | 16 | Decremented loop register value |

## Verification
The assertions take for granted that whenever `issue` is high the instruction, program counter, flags and loop value hold known values for that edge, and that `issue` itself is never unknown once reset is released. The bench drives every input at the falling edge with fully defined values, holds them across the rising edge that samples them, and lowers `issue` between table entries except in the back-to-back test, so each property sees exactly one defined issue per result cycle.

// File: rtl/bl_pkg.sv
package bl_pkg;

    localparam int DATA_W     = 16;
    localparam int BR_OFF_W   = 8;
    localparam int LOOP_OFF_W = 6;
    localparam int IDX_W      = 3;
    localparam int SEL_W      = 4;

    typedef enum logic [1:0] {
        CLS_PASS   = 2'd0,
        CLS_BRANCH = 2'd1,
        CLS_LOOP   = 2'd2
    } instr_cls_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BRANCH = 2'd1,
        ST_LOOP   = 2'd2,
        ST_PASS   = 2'd3
    } bl_state_t;

endpackage

// File: rtl/bl_decode.sv
module bl_decode
    import bl_pkg::*;
#(
    parameter int W      = DATA_W,
    parameter int OFF_W  = BR_OFF_W,
    parameter int LOFF_W = LOOP_OFF_W,
    parameter int RIX_W  = IDX_W
) (
    input  logic [W-1:0]      instr,
    output instr_cls_t        cls,
    output logic [SEL_W-1:0]  cond_sel,
    output logic [OFF_W-1:0]  br_off,
    output logic [LOFF_W-1:0] loop_off,
    output logic [RIX_W-1:0]  loop_reg
);

    localparam int LOOP_TAG_W = W - RIX_W - LOFF_W;
    localparam logic [LOOP_TAG_W-1:0] LOOP_TAG = 7'b0111111;

    logic [W-OFF_W-1:0] hi_byte;
    logic               hi_group_ok;

    assign hi_byte  = instr[W-1:OFF_W];
    assign br_off   = instr[OFF_W-1:0];
    assign loop_off = instr[LOFF_W-1:0];
    assign loop_reg = instr[LOFF_W+RIX_W-1:LOFF_W];
    assign cond_sel = {instr[W-1], instr[OFF_W+2:OFF_W]};

    // bits 14..11 of the high byte must be clear for either branch group
    assign hi_group_ok = (hi_byte[W-OFF_W-2:3] == '0);

    always_comb begin
        cls = CLS_PASS;
        if (instr[W-1:W-LOOP_TAG_W] == LOOP_TAG) begin
            cls = CLS_LOOP;
        end else if (hi_group_ok && (hi_byte[W-OFF_W-1] || (hi_byte[2:0] != 3'd0))) begin
            cls = CLS_BRANCH;
        end
    end

endmodule

// File: rtl/bl_cond.sv
module bl_cond
    import bl_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             n,
    input  logic             z,
    input  logic             v,
    input  logic             c,
    output logic             met
);

    logic nv;
    assign nv = n ^ v;

    always_comb begin
        unique case (sel)
            4'b0000: met = 1'b0;
            4'b0001: met = 1'b1;
            4'b0010: met = !z;
            4'b0011: met = z;
            4'b0100: met = !nv;
            4'b0101: met = nv;
            4'b0110: met = !(z | nv);
            4'b0111: met = z | nv;
            4'b1000: met = !n;
            4'b1001: met = n;
            4'b1010: met = !(c | z);
            4'b1011: met = c | z;
            4'b1100: met = !v;
            4'b1101: met = v;
            4'b1110: met = !c;
            4'b1111: met = c;
            default: met = 1'b0;
        endcase
    end

endmodule

// File: rtl/bl_target.sv
module bl_target
    import bl_pkg::*;
#(
    parameter int W      = DATA_W,
    parameter int OFF_W  = BR_OFF_W,
    parameter int LOFF_W = LOOP_OFF_W
) (
    input  logic [W-1:0]      pc,
    input  logic [OFF_W-1:0]  br_off,
    input  logic [LOFF_W-1:0] loop_off,
    input  logic [W-1:0]      count,
    output logic [W-1:0]      br_dest,
    output logic [W-1:0]      loop_dest,
    output logic [W-1:0]      count_dec,
    output logic              count_live
);

    localparam int BR_EXT_W   = W - OFF_W - 1;
    localparam int LOOP_EXT_W = W - LOFF_W - 1;

    logic [W-1:0] br_bytes;
    logic [W-1:0] loop_bytes;

    // word offsets become byte distances by a left shift of one
    assign br_bytes   = {{BR_EXT_W{br_off[OFF_W-1]}}, br_off, 1'b0};
    assign loop_bytes = {{LOOP_EXT_W{1'b0}}, loop_off, 1'b0};

    assign br_dest    = pc + br_bytes;
    assign loop_dest  = pc - loop_bytes;
    assign count_dec  = count - W'(1);
    assign count_live = (count_dec != '0);

endmodule

// File: rtl/bl_unit.sv
module bl_unit
    import bl_pkg::*;
#(
    parameter int W      = DATA_W,
    parameter int OFF_W  = BR_OFF_W,
    parameter int LOFF_W = LOOP_OFF_W,
    parameter int RIX_W  = IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [W-1:0]     instr,
    input  logic [W-1:0]     pc_in,
    input  logic             flag_n,
    input  logic             flag_z,
    input  logic             flag_v,
    input  logic             flag_c,
    input  logic [W-1:0]     loop_val,
    output logic             done,
    output logic             ctl_hit,
    output logic             taken,
    output logic [W-1:0]     pc_out,
    output logic             loop_wr,
    output logic [RIX_W-1:0] loop_idx,
    output logic [W-1:0]     loop_data
);

    instr_cls_t        cls;
    logic [SEL_W-1:0]  cond_sel;
    logic [OFF_W-1:0]  br_off;
    logic [LOFF_W-1:0] loop_off;
    logic [RIX_W-1:0]  loop_reg;
    logic              cond_met;
    logic [W-1:0]      br_dest;
    logic [W-1:0]      loop_dest;
    logic [W-1:0]      count_dec;
    logic              count_live;

    bl_state_t         state_q;
    bl_state_t         state_d;
    logic              go_q;
    logic              go_d;
    logic [W-1:0]      dest_q;
    logic [W-1:0]      dest_d;
    logic [RIX_W-1:0]  idx_q;
    logic [W-1:0]      cnt_q;

    bl_decode #(.W(W), .OFF_W(OFF_W), .LOFF_W(LOFF_W), .RIX_W(RIX_W)) u_decode (
        .instr    (instr),
        .cls      (cls),
        .cond_sel (cond_sel),
        .br_off   (br_off),
        .loop_off (loop_off),
        .loop_reg (loop_reg)
    );

    bl_cond u_cond (
        .sel (cond_sel),
        .n   (flag_n),
        .z   (flag_z),
        .v   (flag_v),
        .c   (flag_c),
        .met (cond_met)
    );

    bl_target #(.W(W), .OFF_W(OFF_W), .LOFF_W(LOFF_W)) u_target (
        .pc         (pc_in),
        .br_off     (br_off),
        .loop_off   (loop_off),
        .count      (loop_val),
        .br_dest    (br_dest),
        .loop_dest  (loop_dest),
        .count_dec  (count_dec),
        .count_live (count_live)
    );

    // next state and the result to carry into the output cycle
    always_comb begin
        state_d = ST_IDLE;
        go_d    = 1'b0;
        dest_d  = pc_in;
        if (issue) begin
            unique case (cls)
                CLS_BRANCH: begin
                    state_d = ST_BRANCH;
                    go_d    = cond_met;
                    dest_d  = cond_met ? br_dest : pc_in;
                end
                CLS_LOOP: begin
                    state_d = ST_LOOP;
                    go_d    = count_live;
                    dest_d  = count_live ? loop_dest : pc_in;
                end
                default: begin
                    state_d = ST_PASS;
                end
            endcase
        end
    end

    // state register with its captured results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            go_q    <= 1'b0;
            dest_q  <= '0;
            idx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            go_q    <= go_d;
            dest_q  <= dest_d;
            if (issue && (cls == CLS_LOOP)) begin
                idx_q <= loop_reg;
                cnt_q <= count_dec;
            end
        end
    end

    // outputs decoded from the current state
    always_comb begin
        done      = 1'b0;
        ctl_hit   = 1'b0;
        taken     = 1'b0;
        pc_out    = '0;
        loop_wr   = 1'b0;
        loop_idx  = idx_q;
        loop_data = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_BRANCH: begin
                done    = 1'b1;
                ctl_hit = 1'b1;
                taken   = go_q;
                pc_out  = dest_q;
            end
            ST_LOOP: begin
                done    = 1'b1;
                ctl_hit = 1'b1;
                taken   = go_q;
                pc_out  = dest_q;
                loop_wr = 1'b1;
            end
            ST_PASS: begin
                done    = 1'b1;
                pc_out  = dest_q;
            end
            default: begin
            end
        endcase
    end

    // R2: no issue, no result cycle
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> (!done && !taken && !loop_wr && !ctl_hit));

    // R2 and R9: every issue yields a result cycle
    a_r9_issue_done: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> done);

    // R6: whenever control does not move, the next PC is the incoming PC
    a_r6_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (taken || pc_out == $past(pc_in)));

    // R3: the unconditional branch always moves
    a_r3_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && instr[W-1:OFF_W] == 8'h01) |=> (taken && ctl_hit));

    // R7: every loop issue writes back the decremented count
    a_r7_loop_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && instr[W-1:W-7] == 7'b0111111) |=>
            (loop_wr && loop_data == $past(loop_val) - W'(1)));

    // R8: a count reaching zero stops the loop
    a_r8_zero_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_wr && loop_data == '0) |-> !taken);

    // R7: the write strobe only accompanies a control-transfer result
    a_r7_strobe_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        loop_wr |-> (ctl_hit && done));

endmodule

// File: tb/tb_bl_unit.sv
module tb_bl_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 25;
    localparam int VW = 90;

    // instr, pc, {N,Z,V,C}, loop_val, ctl, taken, wr, idx, exp_pc, exp_data
    localparam logic [VW-1:0] VEC [NV] = '{
        {16'h0105, 16'h1000, 4'b0000, 16'h0000, 1'b1, 1'b1, 1'b0, 3'd0, 16'h100A, 16'h0000},
        {16'h02FE, 16'h1000, 4'b0000, 16'h0000, 1'b1, 1'b1, 1'b0, 3'd0, 16'h0FFC, 16'h0000},
        {16'h02FE, 16'h1000, 4'b0100, 16'h0000, 1'b1, 1'b0, 1'b0, 3'd0, 16'h1000, 16'h0000},
        {16'h0310, 16'h1000, 4'b0100, 16'h0000, 1'b1, 1'b1, 1'b0, 3'd0, 16'h1020, 16'h0000},
        {16'h0404, 16'h1000, 4'b1010, 16'h0000, 1'b1, 1'b1, 1'b0, 3'd0, 16'h1008, 16'h0000},
        {16'h0504, 16'h1000, 4'b1000, 16'h0000, 1'b1, 1'b1, 1'b0, 3'd0, 16'h1008, 16'h0000},
        {16'h0604, 16'h1000, 4'b0100, 16'h0000, 1'b1, 1'b0, 1'b0, 3'd0, 16'h1000, 16'h0000},
        {16'h0704, 16'h1000, 4'b0100, 16'h0000, 1'b1, 1'b1, 1'b0, 3'd0, 16'h1008, 16'h0000},
        {16'h8004, 16'h1000, 4'b1000, 16'h0000, 1'b1, 1'b0, 1'b0, 3'd0, 16'h1000, 16'h0000},
        {16'h8104, 16'h1000, 4'b1000, 16'h0000, 1'b1, 1'b1, 1'b0, 3'd0, 16'h1008, 16'h0000},
        {16'h8204, 16'h1000, 4'b0000, 16'h0000, 1'b1, 1'b1, 1'b0, 3'd0, 16'h1008, 16'h0000},
        {16'h8304, 16'h1000, 4'b0001, 16'h0000, 1'b1, 1'b1, 1'b0, 3'd0, 16'h1008, 16'h0000},
        {16'h8404, 16'h1000, 4'b0010, 16'h0000, 1'b1, 1'b0, 1'b0, 3'd0, 16'h1000, 16'h0000},
        {16'h8504, 16'h1000, 4'b0010, 16'h0000, 1'b1, 1'b1, 1'b0, 3'd0, 16'h1008, 16'h0000},
        {16'h8604, 16'h1000, 4'b0001, 16'h0000, 1'b1, 1'b0, 1'b0, 3'd0, 16'h1000, 16'h0000},
        {16'h8704, 16'h1000, 4'b0001, 16'h0000, 1'b1, 1'b1, 1'b0, 3'd0, 16'h1008, 16'h0000},
        {16'h0180, 16'h1000, 4'b0000, 16'h0000, 1'b1, 1'b1, 1'b0, 3'd0, 16'h0F00, 16'h0000},
        {16'h017F, 16'h1000, 4'b0000, 16'h0000, 1'b1, 1'b1, 1'b0, 3'd0, 16'h10FE, 16'h0000},
        {16'h01FF, 16'h0000, 4'b0000, 16'h0000, 1'b1, 1'b1, 1'b0, 3'd0, 16'hFFFE, 16'h0000},
        {16'h0000, 16'h1000, 4'b1111, 16'h0000, 1'b0, 1'b0, 1'b0, 3'd0, 16'h1000, 16'h0000},
        {16'h8800, 16'h1000, 4'b1111, 16'h0000, 1'b0, 1'b0, 1'b0, 3'd0, 16'h1000, 16'h0000},
        {16'h7E85, 16'h1000, 4'b0000, 16'h0003, 1'b1, 1'b1, 1'b1, 3'd2, 16'h0FF6, 16'h0002},
        {16'h7F7F, 16'h1000, 4'b0000, 16'h0001, 1'b1, 1'b0, 1'b1, 3'd5, 16'h1000, 16'h0000},
        {16'h7E01, 16'h1000, 4'b0000, 16'h0000, 1'b1, 1'b1, 1'b1, 3'd0, 16'h0FFE, 16'hFFFF},
        {16'h7C05, 16'h1000, 4'b1111, 16'h0005, 1'b0, 1'b0, 1'b0, 3'd0, 16'h1000, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] pc_in = '0;
    logic        flag_n = 1'b0;
    logic        flag_z = 1'b0;
    logic        flag_v = 1'b0;
    logic        flag_c = 1'b0;
    logic [15:0] loop_val = '0;
    logic        done;
    logic        ctl_hit;
    logic        taken;
    logic [15:0] pc_out;
    logic        loop_wr;
    logic [2:0]  loop_idx;
    logic [15:0] loop_data;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bl_unit dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .pc_in(pc_in),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
        .loop_val(loop_val), .done(done), .ctl_hit(ctl_hit), .taken(taken),
        .pc_out(pc_out), .loop_wr(loop_wr), .loop_idx(loop_idx), .loop_data(loop_data)
    );

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] ins, input logic [15:0] pc,
                         input logic [3:0] nzvc, input logic [15:0] lv);
        issue    = 1'b1;
        instr    = ins;
        pc_in    = pc;
        {flag_n, flag_z, flag_v, flag_c} = nzvc;
        loop_val = lv;
    endtask

    task automatic chk_quiet(input string tag);
        chk(tag, "done", 16'(done), 16'h0);
        chk(tag, "ctl_hit", 16'(ctl_hit), 16'h0);
        chk(tag, "taken", 16'(taken), 16'h0);
        chk(tag, "loop_wr", 16'(loop_wr), 16'h0);
        chk(tag, "pc_out", pc_out, 16'h0000);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk_quiet("R1");
        chk("R1", "loop_idx", 16'(loop_idx), 16'h0);
        chk("R1", "loop_data", loop_data, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk_quiet("R1");

        // table walk: R3, R4, R5, R6, R7, R8
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            string tag;
            v = VEC[i];
            if (v[35]) tag = v[36] ? "R7 R8" : "R7 R8 stop";
            else if (!v[37]) tag = "R6";
            else if (v[89]) tag = v[36] ? "R4 R5" : "R4 R6";
            else tag = v[36] ? "R3 R5" : "R3 R6";
            drive(v[89:74], v[73:58], v[57:54], v[53:38]);
            @(negedge clk);
            issue = 1'b0;
            chk(tag, "done", 16'(done), 16'h1);
            chk(tag, "ctl_hit", 16'(ctl_hit), 16'(v[37]));
            chk(tag, "taken", 16'(taken), 16'(v[36]));
            chk(tag, "loop_wr", 16'(loop_wr), 16'(v[35]));
            chk(tag, "pc_out", pc_out, v[31:16]);
            if (v[35]) begin
                chk(tag, "loop_idx", 16'(loop_idx), 16'(v[34:32]));
                chk(tag, "loop_data", loop_data, v[15:0]);
            end
            @(negedge clk);
            chk_quiet("R2");
        end

        // R9: back-to-back issues
        drive(16'h0302, 16'h2000, 4'b0100, 16'h0000);
        @(negedge clk);
        drive(16'h7E42, 16'h3000, 4'b0000, 16'h0010);
        chk("R9", "done first", 16'(done), 16'h1);
        chk("R9", "pc first", pc_out, 16'h2004);
        @(negedge clk);
        drive(16'h02FF, 16'h4000, 4'b0100, 16'h0000);
        chk("R9", "done second", 16'(done), 16'h1);
        chk("R9", "pc second", pc_out, 16'h2FFC);
        chk("R9", "data second", loop_data, 16'h000F);
        chk("R9", "idx second", 16'(loop_idx), 16'h1);
        @(negedge clk);
        issue = 1'b0;
        chk("R9", "taken third", 16'(taken), 16'h0);
        chk("R9", "pc third", pc_out, 16'h4000);
        chk("R9", "wr third", 16'(loop_wr), 16'h0);
        @(negedge clk);
        chk_quiet("R2");

        // R1: reset in the middle of a result
        drive(16'h7E41, 16'h1000, 4'b0000, 16'h0009);
        @(negedge clk);
        issue = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk_quiet("R1");
        chk("R1", "loop_data after reset", loop_data, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule